// File: doc/BRIEF.md
# GPIO Line Event Interrupt Detector

This block watches every input line of one I/O bank and turns programmable per-line events into one interrupt request for the whole bank. Each line has a three-bit event code that comes from configuration storage outside the block. The code selects a falling edge, a rising edge, either edge, a low level or a high level. Before detection, each raw line passes through a synchronizer. It can then pass through a glitch filter paced by a slow-clock tick.

Every detected event sets a sticky bit in a per-line status register. This happens whether or not the line is masked. Software controls the interrupt mask through two write-only ports: one sets mask bits and the other clears them. The mask can be read back. A read of the status register returns the pending events and empties the register in the same access, so no separate acknowledge is needed. The interrupt output is high whenever a pending status bit has its mask bit set.

Top module: `gpio_evt_irq`

## Requirements
- R1: After reset the mask register and the status register both read as zero, and `irq` is low.
- R2: A write to byte address 0x20 sets every mask bit whose write-data bit is 1 and leaves the others unchanged. The mask reads back at address 0x28, with bit i belonging to line i.
- R3: A write to byte address 0x24 clears every mask bit whose write-data bit is 1 and leaves the others unchanged.
- R4: Line i takes its code from `cfg_evt_sel[3*i+2:3*i]`. The codes are: 0 falling edge, 1 rising edge, 2 either edge, 3 low level, 4 high level. An edge is found by comparing the conditioned level with its value one cycle earlier. A change on `line_in` reaches the status register at the third rising clock edge after it is applied.
- R5: Event codes 5, 6 and 7 never set a status bit, whatever the line does.
- R6: A level event sets its status bit again on every cycle while the level lasts. A level that is still present is therefore reported again by the next status read.
- R7: A read at address 0x2C returns the status register and clears it. An event detected in the same cycle as that read is kept and appears in the next read.
- R8: Status bits are recorded whether or not the line's mask bit is set. `irq` is high exactly when some line has both its status bit and its mask bit set.
- R9: The filter is active on line i only when both `cfg_filt_en[i]` and `cfg_filt_slow[i]` are 1. Otherwise the synchronized level is used directly. While the filter is active, the filtered level takes a new value only at a `slow_tick` cycle, and only if that value has been present without change since before the previous tick. A pulse shorter than one tick interval is therefore rejected.
- R10: A read of any address other than 0x28 and 0x2C returns zero and leaves the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 32 | Raw input lines of the bank |
| cfg_evt_sel | input | 96 | Three-bit event code per line |
| cfg_filt_en | input | 32 | First filter enable bit per line |
| cfg_filt_slow | input | 32 | Second filter enable bit per line (slow-clock filtering) |
| slow_tick | input | 1 | One-cycle pulse each half slow-clock period |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq | output | 1 | Combined bank interrupt request |

## Verification
A wrong mask bit shows on `irq` in the cycle after the write that should have changed it, and on the next read of address 0x28. A corrupted status bit shows on `irq` at once if its line is masked, and otherwise at the next read of 0x2C. A faulty clear-on-read shows on the read that follows, either as a bit that should be gone or as a same-cycle event that was lost. A faulty edge history or filter state shows as events that are missing or extra. These appear three cycles after the line moves, or at the second tick while filtering is active.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;

    localparam logic [BUS_AW-1:0] OFS_MASK_SET = 8'h20;
    localparam logic [BUS_AW-1:0] OFS_MASK_CLR = 8'h24;
    localparam logic [BUS_AW-1:0] OFS_MASK_RD  = 8'h28;
    localparam logic [BUS_AW-1:0] OFS_STATUS   = 8'h2C;

    typedef enum logic [2:0] {
        EVT_FALL = 3'd0,
        EVT_RISE = 3'd1,
        EVT_BOTH = 3'd2,
        EVT_LOW  = 3'd3,
        EVT_HIGH = 3'd4
    } evt_code_e;

    // Decode one line's event from its code, last level and present level.
    function automatic logic evt_hit(input logic [2:0] code, input logic prev, input logic cur);
        logic hit;
        case (code)
            EVT_FALL: hit = prev & ~cur;
            EVT_RISE: hit = ~prev & cur;
            EVT_BOTH: hit = prev ^ cur;
            EVT_LOW:  hit = ~cur;
            EVT_HIGH: hit = cur;
            default:  hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][N-1:0] pipe;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.pipe[STAGES-1];
endmodule

// File: rtl/gpio_evt_filter.sv
module gpio_evt_filter #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    input  logic [N-1:0] filt_on,
    input  logic         tick,
    output logic [N-1:0] lvl
);
    typedef struct packed {
        logic [N-1:0] cand;
        logic [N-1:0] armed;
        logic [N-1:0] filt;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (raw[i] != st_q.cand[i]) begin
                st_d.cand[i]  = raw[i];
                st_d.armed[i] = 1'b0;
            end else if (tick) begin
                if (st_q.armed[i]) st_d.filt[i]  = st_q.cand[i];
                else               st_d.armed[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_sel
        assign lvl[g] = filt_on[g] ? st_q.filt[g] : raw[g];
    end
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
    import gpio_evt_pkg::*;
#(
    parameter int N = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   lvl,
    input  logic [3*N-1:0] sel,
    output logic [N-1:0]   evt
);
    typedef struct packed {
        logic [N-1:0] prev;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_line
        assign evt[g] = evt_hit(sel[3*g +: 3], st_q.prev[g], lvl[g]);
    end
endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
    import gpio_evt_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      evt,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic [N-1:0]      mask,
    output logic [N-1:0]      status,
    output logic              irq
);
    typedef struct packed {
        logic [N-1:0] mask;
        logic [N-1:0] status;
    } regs_t;

    regs_t st_d, st_q;
    logic  wr_set, wr_clr, rd_stat;

    assign wr_set  = bus_sel &  bus_wr & (bus_addr == OFS_MASK_SET);
    assign wr_clr  = bus_sel &  bus_wr & (bus_addr == OFS_MASK_CLR);
    assign rd_stat = bus_sel & ~bus_wr & (bus_addr == OFS_STATUS);

    always_comb begin
        st_d = st_q;
        if (wr_set) st_d.mask = st_q.mask |  bus_wdata[N-1:0];
        if (wr_clr) st_d.mask = st_q.mask & ~bus_wdata[N-1:0];
        st_d.status = (rd_stat ? '0 : st_q.status) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                OFS_MASK_RD: bus_rdata[N-1:0] = st_q.mask;
                OFS_STATUS:  bus_rdata[N-1:0] = st_q.status;
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign mask   = st_q.mask;
    assign status = st_q.status;
    assign irq    = |(st_q.status & st_q.mask);
endmodule

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq
    import gpio_evt_pkg::*;
#(
    parameter int N           = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      line_in,
    input  logic [3*N-1:0]    cfg_evt_sel,
    input  logic [N-1:0]      cfg_filt_en,
    input  logic [N-1:0]      cfg_filt_slow,
    input  logic              slow_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              irq
);
    logic [N-1:0] sync_w, lvl_w, evt_w, mask_w, status_w, filt_on_w;

    assign filt_on_w = cfg_filt_en & cfg_filt_slow;

    gpio_evt_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(line_in), .dout(sync_w)
    );

    gpio_evt_filter #(.N(N)) u_filt (
        .clk(clk), .rst_n(rst_n), .raw(sync_w), .filt_on(filt_on_w),
        .tick(slow_tick), .lvl(lvl_w)
    );

    gpio_evt_detect #(.N(N)) u_det (
        .clk(clk), .rst_n(rst_n), .lvl(lvl_w), .sel(cfg_evt_sel), .evt(evt_w)
    );

    gpio_evt_regs #(.N(N)) u_regs (
        .clk(clk), .rst_n(rst_n), .evt(evt_w), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .mask(mask_w), .status(status_w), .irq(irq)
    );
endmodule

// File: rtl/gpio_evt_irq_chk.sv
module gpio_evt_irq_chk
    import gpio_evt_pkg::*;
#(
    parameter int N = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic [N-1:0]      mask_q,
    input logic [N-1:0]      status_q,
    input logic [N-1:0]      evt,
    input logic [3*N-1:0]    sel,
    input logic              irq
);
    logic rd_st, rd_other;
    assign rd_st    = bus_sel && !bus_wr && bus_addr == OFS_STATUS;
    assign rd_other = bus_sel && !bus_wr && bus_addr != OFS_STATUS;

    // R2
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_MASK_SET)
        |=> ((mask_q & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0])));

    // R3
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_MASK_CLR)
        |=> ((mask_q & $past(bus_wdata[N-1:0])) == '0));

    // R7
    clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_st |=> (status_q == $past(evt)));

    // R10
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_st || rd_other) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    for (genvar g = 0; g < N; g++) begin : g_unused
        // R5
        unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel[3*g +: 3] > 3'd4) |-> !evt[g]);
    end
endmodule

bind gpio_evt_irq gpio_evt_irq_chk #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .mask_q(mask_w),
    .status_q(status_w), .evt(evt_w), .sel(cfg_evt_sel), .irq(irq)
);

// File: tb/test_gpio_evt_irq.sv
module test_gpio_evt_irq;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  line_in = '0;
    logic [3*N-1:0] cfg_evt_sel = '0;
    logic [N-1:0]  cfg_filt_en = '0;
    logic [N-1:0]  cfg_filt_slow = '0;
    logic          slow_tick = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit rnd_mode = 0;
    int tick_cnt = 0;

    always #5 clk = ~clk;

    gpio_evt_irq i_gpio_evt_irq (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .cfg_evt_sel(cfg_evt_sel),
        .cfg_filt_en(cfg_filt_en), .cfg_filt_slow(cfg_filt_slow),
        .slow_tick(slow_tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    // Reference model state, built from the requirements.
    logic [N-1:0] m_s1, m_s2, m_cand, m_arm, m_filt, m_prev, m_stat, m_mask;

    function automatic logic ref_evt(input logic [2:0] c, input logic p, input logic v);
        case (c)
            3'd0: return p & ~v;
            3'd1: return ~p & v;
            3'd2: return p ^ v;
            3'd3: return ~v;
            3'd4: return v;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] ref_rdata(input logic [7:0] a);
        if (a == 8'h28) return m_mask;
        if (a == 8'h2C) return m_stat;
        return 32'h0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_cand = '0; m_arm = '0;
            m_filt = '0; m_prev = '0; m_stat = '0; m_mask = '0;
        end else begin
            logic [N-1:0] lv, ev, on;
            on = cfg_filt_en & cfg_filt_slow;
            for (int i = 0; i < N; i++) begin
                lv[i] = on[i] ? m_filt[i] : m_s2[i];
                ev[i] = ref_evt(cfg_evt_sel[3*i +: 3], m_prev[i], lv[i]);
            end
            if (bus_sel && !bus_wr && bus_addr == 8'h2C) m_stat = '0;
            m_stat = m_stat | ev;
            if (bus_sel && bus_wr && bus_addr == 8'h20) m_mask = m_mask | bus_wdata;
            if (bus_sel && bus_wr && bus_addr == 8'h24) m_mask = m_mask & ~bus_wdata;
            for (int i = 0; i < N; i++) begin
                if (m_s2[i] != m_cand[i]) begin
                    m_cand[i] = m_s2[i]; m_arm[i] = 1'b0;
                end else if (slow_tick) begin
                    if (m_arm[i]) m_filt[i] = m_cand[i];
                    else          m_arm[i] = 1'b1;
                end
            end
            m_prev = lv;
            m_s2 = m_s1;
            m_s1 = line_in;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk("R8 irq", {31'b0, irq}, {31'b0, |(m_stat & m_mask)});
            if (bus_sel && !bus_wr) begin
                if (bus_addr == 8'h28)      chk("R2 mask read", bus_rdata, ref_rdata(bus_addr));
                else if (bus_addr == 8'h2C) chk("R7 status read", bus_rdata, ref_rdata(bus_addr));
                else                        chk("R10 unmapped read", bus_rdata, ref_rdata(bus_addr));
            end
        end
    end

    // Slow tick: every eighth cycle in the directed phase, random later.
    always @(negedge clk) begin
        #1;
        tick_cnt++;
        slow_tick = rnd_mode ? ($urandom % 5 == 0) : (tick_cnt % 8 == 0);
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk); #1 bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk); #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic set_line(input int i, input logic v);
        @(negedge clk); #1 line_in[i] = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd24681));
        idle(3);
        #1 rst_n = 1'b1;
        idle(2);

        // R1 reset state
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        rd(8'h28, d); chk("R1 mask after reset", d, 32'h0);
        rd(8'h2C, d); chk("R1 status after reset", d, 32'h0);

        // R2 / R3 mask set and clear
        wr(8'h20, 32'h0000_00A5);
        rd(8'h28, d); chk("R2 mask set", d, 32'h0000_00A5);
        wr(8'h24, 32'h0000_0005);
        rd(8'h28, d); chk("R3 mask clear", d, 32'h0000_00A0);
        wr(8'h20, 32'h0000_0001);

        // R4 rising edge on line 0
        cfg_evt_sel[2:0] = 3'd1;
        set_line(0, 1'b1);
        idle(5);
        chk("R8 irq on masked event", {31'b0, irq}, 32'h1);
        rd(8'h2C, d); chk("R4 rising edge status", d, 32'h1);
        rd(8'h2C, d); chk("R7 status cleared by read", d, 32'h0);
        chk("R8 irq dropped after read", {31'b0, irq}, 32'h0);

        // R6 high level on line 1
        cfg_evt_sel[5:3] = 3'd4;
        set_line(1, 1'b1);
        idle(5);
        rd(8'h2C, d); chk("R6 level first read", d, 32'h2);
        rd(8'h2C, d); chk("R6 level persists", d, 32'h2);
        cfg_evt_sel[5:3] = 3'd5;
        idle(3);
        rd(8'h2C, d);
        rd(8'h2C, d); chk("R5 code 5 stops level events", d, 32'h0);

        // R5 code 6 on a toggling line
        cfg_evt_sel[8:6] = 3'd6;
        for (int k = 0; k < 6; k++) set_line(2, k[0] ? 1'b0 : 1'b1);
        idle(5);
        rd(8'h2C, d); chk("R5 code 6 no events", d, 32'h0);

        // R8 unmasked line still records status
        cfg_evt_sel[14:12] = 3'd2;
        set_line(4, 1'b1);
        idle(5);
        chk("R8 irq stays low for unmasked line", {31'b0, irq}, 32'h0);
        rd(8'h2C, d); chk("R8 status recorded without mask", d, 32'h10);

        // R7 event in the same cycle as a read is kept
        set_line(4, 1'b0);
        @(negedge clk);
        rd(8'h2C, d); chk("R7 read in event cycle", d, 32'h0);
        rd(8'h2C, d); chk("R7 same-cycle event kept", d, 32'h10);

        // R9 glitch filter on line 3
        cfg_evt_sel[11:9] = 3'd1;
        cfg_filt_en[3] = 1'b1; cfg_filt_slow[3] = 1'b1;
        idle(20);
        set_line(3, 1'b1); set_line(3, 1'b0);
        idle(20);
        rd(8'h2C, d); chk("R9 short pulse rejected", d & 32'h8, 32'h0);
        set_line(3, 1'b1);
        idle(30);
        rd(8'h2C, d); chk("R9 long level passes", d & 32'h8, 32'h8);
        set_line(3, 1'b0);
        idle(30);
        cfg_filt_slow[3] = 1'b0;
        rd(8'h2C, d);
        set_line(3, 1'b1); set_line(3, 1'b0);
        idle(6);
        rd(8'h2C, d); chk("R9 one filter bit leaves filter off", d & 32'h8, 32'h8);

        // R10 unmapped read, status retained
        set_line(4, 1'b1);
        idle(5);
        rd(8'h00, d); chk("R10 unmapped read zero", d, 32'h0);
        rd(8'h2C, d); chk("R10 status survives unmapped read", d, 32'h10);

        // Random phase checked cycle by cycle against the model.
        rnd_mode = 1;
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk); #1;
            if ($urandom % 4 == 0) line_in = $urandom;
            if ($urandom % 50 == 0) cfg_evt_sel = {$urandom, $urandom, $urandom};
            if ($urandom % 60 == 0) begin
                cfg_filt_en = $urandom; cfg_filt_slow = $urandom;
            end
            bus_sel = ($urandom % 3 == 0);
            bus_wr = ($urandom % 3 == 0);
            case ($urandom % 5)
                0: bus_addr = 8'h20;
                1: bus_addr = 8'h24;
                2: bus_addr = 8'h28;
                3: bus_addr = 8'h2C;
                default: bus_addr = 8'($urandom);
            endcase
            bus_wdata = $urandom;
        end
        @(negedge clk); #1 bus_sel = 1'b0;
        idle(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule